// File: doc/BRIEF.md
# Asymmetric Dual-Issue Pairing Unit

Each clock, this block looks at two adjacent decoded instructions, an older one and a younger one, and decides whether both can issue in the same cycle. There are two execution pipes. The wide pipe can run any instruction and is the only one that reaches the vector math unit. The narrow pipe runs only scalar operations and vector stores. The block checks three things: that each instruction can run on the pipe it would get, that the pair fits the read and write port budget of the vector register file, and that the younger instruction does not depend on the older one.

Each instruction is described by a valid bit, a two-bit kind, a memory-operand flag, and three register indices: destination, source A and source B. The decision is registered. One clock edge after a pair is presented, the outputs say whether the older instruction issues and whether the younger one issues with it. They also say which slot feeds the wide pipe and how many vector read and write ports the issued instructions use.

When the pair is refused, only the older instruction issues. The front end then moves the younger one into the older slot for the next cycle. A load-op vector math instruction takes one operand from memory, so it uses only two vector reads. That leaves one read port free for a vector store issued in the same cycle.

Top module: `dual_issue_pairer`

## Requirements
- R1: While `rst_n` is low, and after the first edge that follows reset, `issue_first`, `issue_both`, `fat_from_second`, `rd_ports` and `wr_ports` are all zero.
- R2: Outputs are registered. A pair applied before a rising edge is reflected on the outputs after that edge, and not before it.
- R3: The kind encodings are 0 = scalar, 1 = vector math, 2 = vector load and 3 = vector store. An instruction of kind 1 or 2 never goes to the narrow pipe. A pair made only of kinds 1 and 2 never dual-issues.
- R4: If the younger instruction is kind 0 or 3, it goes to the narrow pipe (`fat_from_second` = 0). Otherwise, if the older one is kind 0 or 3, the two swap: the younger feeds the wide pipe and `fat_from_second` = 1. If neither instruction is kind 0 or 3, the pair is refused.
- R5: Vector port use per instruction is as follows:
  - Vector math with `memop` = 0 uses 3 reads and 1 write.
  - Vector math with `memop` = 1 uses 2 reads and 1 write.
  - A vector load uses 0 reads and 1 write.
  - A vector store uses 1 read and no writes.
  - A scalar instruction uses no vector ports.
  - `rd_ports` and `wr_ports` report the sum over the instructions that issue.
- R6: The pair is refused if its combined reads exceed `RD_PORTS` (3) or its combined writes exceed `WR_PORTS` (1).
- R7: The pair is refused if the older instruction writes a vector register and the younger one reads or writes it. Vector math writes and reads `dst`, reads `srca`, and reads `srcb` only when `memop` = 0. A vector load writes `dst`. A vector store reads `srca`.
- R8: If `s0_valid` is 0, nothing issues, even if `s1_valid` is 1. If `s1_valid` is 0, only the older instruction issues.
- R9: Whenever the pair is refused and the older instruction is valid, `issue_first` = 1, `issue_both` = 0 and `fat_from_second` = 0, and the port counts are those of the older instruction alone.
- R10: A scalar instruction writes scalar `dst` and reads scalar `srca` and `srcb`. The pair is refused if an older scalar instruction writes a scalar register that a younger scalar instruction reads or writes. Scalar and vector register indices never conflict with each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s0_valid | input | 1 | Older slot holds an instruction |
| s0_kind | input | 2 | Older slot kind (0 scalar, 1 vector math, 2 vector load, 3 vector store) |
| s0_memop | input | 1 | Older slot vector math takes one operand from memory |
| s0_dst | input | REG_W | Older slot destination register |
| s0_srca | input | REG_W | Older slot source A |
| s0_srcb | input | REG_W | Older slot source B |
| s1_valid | input | 1 | Younger slot holds an instruction |
| s1_kind | input | 2 | Younger slot kind |
| s1_memop | input | 1 | Younger slot memory-operand flag |
| s1_dst | input | REG_W | Younger slot destination register |
| s1_srca | input | REG_W | Younger slot source A |
| s1_srcb | input | REG_W | Younger slot source B |
| issue_first | output | 1 | Older instruction issues |
| issue_both | output | 1 | Younger instruction issues in the same cycle |
| fat_from_second | output | 1 | The wide pipe takes the younger slot (the pair is swapped) |
| rd_ports | output | 3 | Vector read ports used by the issued instructions |
| wr_ports | output | 3 | Vector write ports used by the issued instructions |

## Verification
The bench builds the block with `REG_W` = 1, two registers per file, and the default budget of 3 reads and 1 write. With one-bit indices, every input combination of both slots fits in 16384 vectors. Each vector is applied, and every output is compared with values the bench works out arithmetically. Two registers are enough to make index collisions common, so every dependency case, every swap case and every budget overflow is reached. Directed pairs name the three canonical cases: a load-op math instruction with a store, math with a standalone load, and math with math. Further directed pairs cover reset and the one-edge latency.

// File: rtl/pair_pkg.sv
package pair_pkg;

    typedef enum logic [1:0] {
        K_SCALAR = 2'd0,
        K_VMATH  = 2'd1,
        K_VLOAD  = 2'd2,
        K_VSTORE = 2'd3
    } kind_e;

    // Wide enough for one slot's port use (0..3) and the issued total.
    localparam int CNT_W = 3;

endpackage

// File: rtl/pair_slot_decode.sv
// Per-slot resource decode: vector port use, narrow-pipe capability and
// one-hot masks of registers written and touched in each register file.
module pair_slot_decode
    import pair_pkg::*;
#(
    parameter int REG_W = 5,
    localparam int NREG = 1 << REG_W
) (
    input  logic             valid,
    input  logic [1:0]       kind,
    input  logic             memop,
    input  logic [REG_W-1:0] dst,
    input  logic [REG_W-1:0] srca,
    input  logic [REG_W-1:0] srcb,
    output logic [CNT_W-1:0] vrd,
    output logic [CNT_W-1:0] vwr,
    output logic             thin_ok,
    output logic [NREG-1:0]  wr_v,
    output logic [NREG-1:0]  tch_v,
    output logic [NREG-1:0]  wr_s,
    output logic [NREG-1:0]  tch_s
);

    kind_e k;

    always_comb begin
        k       = kind_e'(kind);
        vrd     = '0;
        vwr     = '0;
        wr_v    = '0;
        tch_v   = '0;
        wr_s    = '0;
        tch_s   = '0;
        thin_ok = (k == K_SCALAR) || (k == K_VSTORE);
        if (valid) begin
            case (k)
                K_VMATH: begin
                    vwr         = CNT_W'(1);
                    wr_v[dst]   = 1'b1;
                    tch_v[dst]  = 1'b1;
                    tch_v[srca] = 1'b1;
                    if (memop) begin
                        vrd = CNT_W'(2);
                    end else begin
                        vrd         = CNT_W'(3);
                        tch_v[srcb] = 1'b1;
                    end
                end
                K_VLOAD: begin
                    vwr        = CNT_W'(1);
                    wr_v[dst]  = 1'b1;
                    tch_v[dst] = 1'b1;
                end
                K_VSTORE: begin
                    vrd         = CNT_W'(1);
                    tch_v[srca] = 1'b1;
                end
                default: begin
                    wr_s[dst]   = 1'b1;
                    tch_s[dst]  = 1'b1;
                    tch_s[srca] = 1'b1;
                    tch_s[srcb] = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/pair_hazard.sv
// Intra-pair dependency: the younger slot touches a register the older writes.
module pair_hazard #(
    parameter int NREG = 32
) (
    input  logic [NREG-1:0] old_wr_v,
    input  logic [NREG-1:0] old_wr_s,
    input  logic [NREG-1:0] yng_tch_v,
    input  logic [NREG-1:0] yng_tch_s,
    output logic            dep
);

    logic [NREG-1:0] hit_v;
    logic [NREG-1:0] hit_s;

    always_comb begin
        hit_v = old_wr_v & yng_tch_v;
        hit_s = old_wr_s & yng_tch_s;
        dep   = (|hit_v) || (|hit_s);
    end

endmodule

// File: rtl/dual_issue_pairer.sv
module dual_issue_pairer
    import pair_pkg::*;
#(
    parameter int REG_W    = 5,
    parameter int RD_PORTS = 3,
    parameter int WR_PORTS = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s0_valid,
    input  logic [1:0]       s0_kind,
    input  logic             s0_memop,
    input  logic [REG_W-1:0] s0_dst,
    input  logic [REG_W-1:0] s0_srca,
    input  logic [REG_W-1:0] s0_srcb,
    input  logic             s1_valid,
    input  logic [1:0]       s1_kind,
    input  logic             s1_memop,
    input  logic [REG_W-1:0] s1_dst,
    input  logic [REG_W-1:0] s1_srca,
    input  logic [REG_W-1:0] s1_srcb,
    output logic             issue_first,
    output logic             issue_both,
    output logic             fat_from_second,
    output logic [2:0]       rd_ports,
    output logic [2:0]       wr_ports
);

    localparam int NREG  = 1 << REG_W;
    localparam int SUM_W = CNT_W + 1;
    localparam logic [SUM_W-1:0] RD_LIM = SUM_W'(RD_PORTS);
    localparam logic [SUM_W-1:0] WR_LIM = SUM_W'(WR_PORTS);

    typedef struct packed {
        logic             first;
        logic             both;
        logic             swap;
        logic [CNT_W-1:0] rd;
        logic [CNT_W-1:0] wr;
    } decision_t;

    logic [1:0]             sl_valid;
    logic [1:0]             sl_memop;
    logic [1:0][1:0]        sl_kind;
    logic [1:0][REG_W-1:0]  sl_dst;
    logic [1:0][REG_W-1:0]  sl_srca;
    logic [1:0][REG_W-1:0]  sl_srcb;
    logic [1:0][CNT_W-1:0]  sl_vrd;
    logic [1:0][CNT_W-1:0]  sl_vwr;
    logic [1:0]             sl_thin;
    logic [1:0][NREG-1:0]   sl_wr_v;
    logic [1:0][NREG-1:0]   sl_tch_v;
    logic [1:0][NREG-1:0]   sl_wr_s;
    logic [1:0][NREG-1:0]   sl_tch_s;

    assign sl_valid = {s1_valid, s0_valid};
    assign sl_memop = {s1_memop, s0_memop};
    assign sl_kind  = {s1_kind,  s0_kind};
    assign sl_dst   = {s1_dst,   s0_dst};
    assign sl_srca  = {s1_srca,  s0_srca};
    assign sl_srcb  = {s1_srcb,  s0_srcb};

    for (genvar gi = 0; gi < 2; gi++) begin : g_slot
        pair_slot_decode #(.REG_W(REG_W)) u_dec (
            .valid   (sl_valid[gi]),
            .kind    (sl_kind[gi]),
            .memop   (sl_memop[gi]),
            .dst     (sl_dst[gi]),
            .srca    (sl_srca[gi]),
            .srcb    (sl_srcb[gi]),
            .vrd     (sl_vrd[gi]),
            .vwr     (sl_vwr[gi]),
            .thin_ok (sl_thin[gi]),
            .wr_v    (sl_wr_v[gi]),
            .tch_v   (sl_tch_v[gi]),
            .wr_s    (sl_wr_s[gi]),
            .tch_s   (sl_tch_s[gi])
        );
    end

    logic dep;

    pair_hazard #(.NREG(NREG)) u_haz (
        .old_wr_v  (sl_wr_v[0]),
        .old_wr_s  (sl_wr_s[0]),
        .yng_tch_v (sl_tch_v[1]),
        .yng_tch_s (sl_tch_s[1]),
        .dep       (dep)
    );

    decision_t dec_d, dec_q;
    logic [SUM_W-1:0] rd_sum, wr_sum;
    logic straight, swapped, fits, can_pair;

    always_comb begin
        rd_sum   = SUM_W'(sl_vrd[0]) + SUM_W'(sl_vrd[1]);
        wr_sum   = SUM_W'(sl_vwr[0]) + SUM_W'(sl_vwr[1]);
        straight = sl_thin[1];
        swapped  = !sl_thin[1] && sl_thin[0];
        fits     = (rd_sum <= RD_LIM) && (wr_sum <= WR_LIM);
        can_pair = s0_valid && s1_valid && (straight || swapped) && fits && !dep;
        dec_d    = '0;
        if (s0_valid) begin
            dec_d.first = 1'b1;
            dec_d.both  = can_pair;
            dec_d.swap  = can_pair && swapped;
            dec_d.rd    = can_pair ? CNT_W'(rd_sum) : sl_vrd[0];
            dec_d.wr    = can_pair ? CNT_W'(wr_sum) : sl_vwr[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign issue_first     = dec_q.first;
    assign issue_both      = dec_q.both;
    assign fat_from_second = dec_q.swap;
    assign rd_ports        = dec_q.rd;
    assign wr_ports        = dec_q.wr;

endmodule

// File: rtl/pair_issue_checker.sv
module pair_issue_checker #(
    parameter int REG_W    = 5,
    parameter int RD_PORTS = 3,
    parameter int WR_PORTS = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             s0_valid,
    input logic [1:0]       s0_kind,
    input logic [REG_W-1:0] s0_dst,
    input logic             s1_valid,
    input logic [1:0]       s1_kind,
    input logic [REG_W-1:0] s1_srca,
    input logic             issue_first,
    input logic             issue_both,
    input logic             fat_from_second,
    input logic [2:0]       rd_ports,
    input logic [2:0]       wr_ports
);

    logic s0_wide_only, s1_wide_only;
    assign s0_wide_only = (s0_kind == 2'd1) || (s0_kind == 2'd2);
    assign s1_wide_only = (s1_kind == 2'd1) || (s1_kind == 2'd2);

    assert_wide_only_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_valid && s1_valid && s0_wide_only && s1_wide_only) |=> !issue_both);

    assert_port_budget_R6: assert property (@(posedge clk) disable iff (!rst_n)
        issue_both |-> (rd_ports <= 3'(RD_PORTS) && wr_ports <= 3'(WR_PORTS)));

    assert_load_store_dep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_valid && s1_valid && s0_kind == 2'd2 && s1_kind == 2'd3 && s0_dst == s1_srca)
        |=> !issue_both);

    assert_no_older_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !s0_valid |=> (!issue_first && !issue_both));

    assert_both_needs_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        issue_both |-> issue_first);

    assert_swap_only_when_paired_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fat_from_second |-> issue_both);

endmodule

bind dual_issue_pairer pair_issue_checker #(
    .REG_W(REG_W), .RD_PORTS(RD_PORTS), .WR_PORTS(WR_PORTS)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .s0_valid(s0_valid), .s0_kind(s0_kind), .s0_dst(s0_dst),
    .s1_valid(s1_valid), .s1_kind(s1_kind), .s1_srca(s1_srca),
    .issue_first(issue_first), .issue_both(issue_both),
    .fat_from_second(fat_from_second), .rd_ports(rd_ports), .wr_ports(wr_ports)
);

// File: tb/sim_dual_issue_pairer.sv
`timescale 1ns/1ps
module sim_dual_issue_pairer;

    localparam int RW = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s0_valid, s0_memop, s1_valid, s1_memop;
    logic [1:0] s0_kind, s1_kind;
    logic [RW-1:0] s0_dst, s0_srca, s0_srcb, s1_dst, s1_srca, s1_srcb;
    logic issue_first, issue_both, fat_from_second;
    logic [2:0] rd_ports, wr_ports;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dual_issue_pairer #(.REG_W(RW), .RD_PORTS(3), .WR_PORTS(1)) u0 (
        .clk(clk), .rst_n(rst_n),
        .s0_valid(s0_valid), .s0_kind(s0_kind), .s0_memop(s0_memop),
        .s0_dst(s0_dst), .s0_srca(s0_srca), .s0_srcb(s0_srcb),
        .s1_valid(s1_valid), .s1_kind(s1_kind), .s1_memop(s1_memop),
        .s1_dst(s1_dst), .s1_srca(s1_srca), .s1_srcb(s1_srcb),
        .issue_first(issue_first), .issue_both(issue_both),
        .fat_from_second(fat_from_second), .rd_ports(rd_ports), .wr_ports(wr_ports)
    );

    task automatic check(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic drive(input int v);
        s0_valid = v[0]; s0_kind = v[2:1]; s0_memop = v[3];
        s0_dst = v[4];   s0_srca = v[5];   s0_srcb = v[6];
        s1_valid = v[7]; s1_kind = v[9:8]; s1_memop = v[10];
        s1_dst = v[11];  s1_srca = v[12];  s1_srcb = v[13];
    endtask

    function automatic int vreads(input int k, input int m);
        if (k == 1) return (m != 0) ? 2 : 3;
        if (k == 3) return 1;
        return 0;
    endfunction

    function automatic int vwrites(input int k);
        return (k == 1 || k == 2) ? 1 : 0;
    endfunction

    function automatic bit narrow_ok(input int k);
        return (k == 0 || k == 3);
    endfunction

    // Expected decision: {first, both, swap, rd, wr}
    task automatic model(input int v, output int ef, output int eb, output int es,
                         output int er, output int ew);
        int v0 = v[0], k0 = v[2:1], m0 = v[3], d0 = v[4];
        int v1 = v[7], k1 = v[9:8], m1 = v[10], d1 = v[11], a1 = v[12], b1 = v[13];
        bit depd = 0;
        bit pair;
        if (k0 == 1 || k0 == 2) begin
            if (k1 == 1) depd = (d1 == d0) || (a1 == d0) || (m1 == 0 && b1 == d0);
            if (k1 == 2) depd = (d1 == d0);
            if (k1 == 3) depd = (a1 == d0);
        end else if (k0 == 0 && k1 == 0) begin
            depd = (d1 == d0) || (a1 == d0) || (b1 == d0);
        end
        pair = v0 && v1 && (narrow_ok(k1) || narrow_ok(k0)) &&
               (vreads(k0, m0) + vreads(k1, m1) <= 3) &&
               (vwrites(k0) + vwrites(k1) <= 1) && !depd;
        ef = v0;
        eb = pair;
        es = pair && !narrow_ok(k1);
        er = v0 ? vreads(k0, m0) + (pair ? vreads(k1, m1) : 0) : 0;
        ew = v0 ? vwrites(k0) + (pair ? vwrites(k1) : 0) : 0;
    endtask

    // Pack fields into a vector: slot = {srcb, srca, dst, memop, kind, valid}
    function automatic int pk(input int va, input int ka, input int ma, input int da,
                              input int aa, input int ba, input int vb, input int kb,
                              input int mb, input int db, input int ab, input int bb);
        return va | (ka << 1) | (ma << 3) | (da << 4) | (aa << 5) | (ba << 6) |
               (vb << 7) | (kb << 8) | (mb << 10) | (db << 11) | (ab << 12) | (bb << 13);
    endfunction

    task automatic step_and_check(input int v, input string tag);
        int ef, eb, es, er, ew;
        drive(v);
        model(v, ef, eb, es, er, ew);
        @(posedge clk); #1;
        check({tag, " issue_first"}, int'(issue_first), ef);
        check({tag, " issue_both"}, int'(issue_both), eb);
        check({tag, " fat_from_second"}, int'(fat_from_second), es);
        check({tag, " rd_ports"}, int'(rd_ports), er);
        check({tag, " wr_ports"}, int'(wr_ports), ew);
    endtask

    initial begin
        #900000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        drive(pk(1,1,1,0,0,0, 1,3,0,1,1,1));
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs cleared in reset despite valid inputs
        check("R1 issue_first", int'(issue_first), 0);
        check("R1 issue_both", int'(issue_both), 0);
        check("R1 rd_ports", int'(rd_ports), 0);
        check("R1 wr_ports", int'(wr_ports), 0);
        drive(0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 after reset", int'(issue_first), 0);

        // R4 R5: load-op math v0 + store v1 pair straight, 3 reads 1 write
        step_and_check(pk(1,1,1,0,0,0, 1,3,0,0,1,0), "R4 R5 loadop+store");
        check("R4 loadop+store pairs", int'(issue_both), 1);
        check("R5 loadop+store reads", int'(rd_ports), 3);
        // R2: change inputs, outputs hold until the next edge
        drive(pk(1,1,0,0,0,0, 1,1,0,1,1,1));
        #1;
        check("R2 hold before edge", int'(issue_both), 1);
        // R3: math + math refused on pipe capability
        step_and_check(pk(1,1,0,0,0,0, 1,1,0,1,1,1), "R3 math+math");
        check("R3 math+math single", int'(issue_both), 0);
        // R6: reg-form math + store exceeds read budget
        step_and_check(pk(1,1,0,0,0,0, 1,3,0,0,1,0), "R6 fma+store");
        check("R6 fma+store single", int'(issue_both), 0);
        check("R9 fma+store reads", int'(rd_ports), 3);
        // R6: math + standalone load exceeds write budget
        step_and_check(pk(1,1,1,0,0,0, 1,2,0,1,0,0), "R6 math+load");
        check("R6 math+load single", int'(issue_both), 0);
        // R4: store then load-op math swaps pipes
        step_and_check(pk(1,3,0,0,0,0, 1,1,1,1,1,1), "R4 swap");
        check("R4 swap flag", int'(fat_from_second), 1);
        // R7: load v1 then store v1 refused
        step_and_check(pk(1,2,0,1,0,0, 1,3,0,0,1,0), "R7 load-store dep");
        check("R7 dep single", int'(issue_both), 0);
        // R10: scalar writes s1, store reads v1: no conflict
        step_and_check(pk(1,0,0,1,0,0, 1,3,0,0,1,0), "R10 separate files");
        check("R10 pairs", int'(issue_both), 1);
        check("R10 no vector use by scalar", int'(rd_ports), 1);
        // R8: younger alone never issues
        step_and_check(pk(0,0,0,0,0,0, 1,0,0,0,0,0), "R8 younger only");
        check("R8 nothing issues", int'(issue_first), 0);

        // Exhaustive sweep of both slots
        for (int v = 0; v < (1 << 14); v++) begin
            int ef, eb, es, er, ew;
            drive(v);
            model(v, ef, eb, es, er, ew);
            @(posedge clk); #1;
            check("R8 R9 issue_first", int'(issue_first), ef);
            check("R6 R7 R10 issue_both", int'(issue_both), eb);
            check("R4 fat_from_second", int'(fat_from_second), es);
            check("R5 rd_ports", int'(rd_ports), er);
            check("R5 wr_ports", int'(wr_ports), ew);
            // R3: a vector math or load never lands on the narrow pipe
            if (issue_both) begin
                int narrow_kind = fat_from_second ? v[2:1] : v[9:8];
                check("R3 narrow pipe kind", int'(narrow_ok(narrow_kind)), 1);
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule